// File: doc/BRIEF.md
# Five-channel multi-mode DMA engine

The engine moves data between two 32-bit addresses through a single-beat memory request port. Each of its five channels holds a source address, a destination address, a beat count and a set of modes. Each beat is a read at the source followed by a write of the same data at the destination. Software loads a channel through a configuration strobe. The channel then waits for its trigger, which is a rising edge on its external request line, a rising edge on its peripheral request line, or a software strobe. When its count is used up, the channel turns itself off, sets a sticky done flag and, if enabled, raises its interrupt.

The transfer mode sets how much work one trigger releases:
- **Step** releases one beat.
- **Block** releases a configured number of beats.
- **Burst** releases the whole count and keeps the memory port until the count is finished.
- **Demand** moves beats for as long as the selected request line stays high.

Among the pending channels, the lowest channel number wins. The engine arbitrates only between beats.

Each channel has a state machine with three states: CH_OFF, CH_WAIT and CH_GO.
- CH_OFF → CH_WAIT: a configuration load with a non-zero count.
- CH_WAIT → CH_GO: a trigger in a mode other than demand.
- CH_GO → CH_WAIT: the beat that uses up the credit.
- CH_WAIT/CH_GO → CH_OFF: the beat that brings the count to zero.

The shared mover has a state machine with three states: MV_IDLE, MV_READ and MV_WRITE.
- MV_IDLE → MV_READ: on a grant.
- MV_READ → MV_WRITE: on the read handshake.
- MV_WRITE → MV_IDLE: on the write handshake.
- MV_WRITE → MV_READ: on the write handshake when a burst channel still has beats left. This is the burst hold.

Top module: `dma_engine`

## Requirements
- R1: During and just after reset, mem_req, ch_active, ch_done and ch_irq are all 0.
- R2: A beat reads at the channel's source address and then writes the data it read to the destination address. Both phases carry the channel's size code on mem_size. A phase completes on a clock edge where mem_req and mem_ready are both 1. While the engine waits for ready, it holds mem_addr, mem_we and mem_size stable.
- R3: The size code selects the data size and the address step: 0 is 8 bits with a step of 1, 1 is 16 bits with a step of 2, and 2 or 3 is 32 bits with a step of 4. After every beat, the source and the destination each update by their own mode code: 0 increments by the step, 1 decrements by the step, and 2 or 3 leaves the address unchanged.
- R4: The trigger code selects the channel's trigger. Code 0 is a rising edge of the channel's ext_req bit, code 1 is a rising edge of its per_req bit, and code 2 or 3 is its sw_trig strobe. Activity on the request lines that the code does not select starts no beat.
- R5: Transfer mode 2 (step) performs one beat per trigger. Holding the selected request line high after its rising edge releases no further beats.
- R6: Transfer mode 3 (block) performs cfg_blk beats per trigger, with a value of 0 taken as 1. A block is cut short when the count reaches zero.
- R7: Transfer mode 1 (burst) performs the whole count after one trigger. No other channel gets a beat until the burst is finished, even a higher-priority one.
- R8: Transfer mode 0 (demand) starts beats while the selected request line is high. It starts no new beat after the line goes low, and it resumes when the line rises again.
- R9: When several channels are pending between beats, the lowest-numbered channel is served first.
- R10: The beat that brings a channel's count to zero clears its ch_active bit and sets its ch_done bit. ch_irq equals ch_done ANDed with the channel's interrupt enable.
- R11: A done_clr pulse clears the channel's done flag. When a done_clr pulse falls in the same cycle that sets done, done stays set. A configuration load also clears done.
- R12: A configuration load aimed at a channel whose ch_active bit is 1 is ignored. The channel finishes its original transfer with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_ch | input | 3 | Channel that the load targets |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_count | input | 16 | Beat count; 0 leaves the channel off |
| cfg_smode | input | 2 | Source update: 0 increment, 1 decrement, 2/3 fixed |
| cfg_dmode | input | 2 | Destination update, same coding as cfg_smode |
| cfg_size | input | 2 | Beat size: 0 8-bit, 1 16-bit, 2/3 32-bit |
| cfg_xmode | input | 2 | Transfer mode: 0 demand, 1 burst, 2 step, 3 block |
| cfg_trig | input | 2 | Trigger: 0 external edge, 1 peripheral edge, 2/3 software |
| cfg_blk | input | 8 | Beats per block trigger |
| cfg_irqen | input | 1 | Interrupt enable |
| ext_req | input | 5 | External request line, one bit per channel |
| per_req | input | 5 | Peripheral request line, one bit per channel |
| sw_trig | input | 5 | Software trigger strobe, one bit per channel |
| done_clr | input | 5 | Done-flag clear strobe, one bit per channel |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write phase, 0 for read phase |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Size code of the current beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken on the read handshake |
| mem_ready | input | 1 | Phase completes on an edge where this and mem_req are 1 |
| ch_active | output | 5 | Channel enable bits |
| ch_done | output | 5 | Sticky done flags |
| ch_irq | output | 5 | Interrupt lines |

## Verification
Two events can fall in the same cycle: the final write handshake sets a channel's done flag, and a software done_clr pulse for that same channel clears it. The bench watches the memory port. When it sees the last write phase about to complete, it pulses done_clr for exactly that cycle. It then expects done and the interrupt to remain set. A later, separate pulse must clear both. This pins down that the set has priority and that the clear is not lost when it arrives alone.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        AM_INC  = 2'd0,
        AM_DEC  = 2'd1,
        AM_FIX  = 2'd2,
        AM_FIX3 = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        XM_DEMAND = 2'd0,
        XM_BURST  = 2'd1,
        XM_STEP   = 2'd2,
        XM_BLOCK  = 2'd3
    } xmode_e;

    typedef enum logic [1:0] {
        TS_EXT  = 2'd0,
        TS_PER  = 2'd1,
        TS_SW   = 2'd2,
        TS_SW3  = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_GO   = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_e;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_count,
    input  logic [1:0]    ld_smode,
    input  logic [1:0]    ld_dmode,
    input  logic [1:0]    ld_size,
    input  logic [1:0]    ld_xmode,
    input  logic [1:0]    ld_trig,
    input  logic [BW-1:0] ld_blk,
    input  logic          ld_irqen,
    input  logic          ext_lvl,
    input  logic          per_lvl,
    input  logic          sw_stb,
    input  logic          beat_done,
    input  logic          done_clr,
    output logic          req,
    output logic          hold,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [1:0]    size,
    output logic          active,
    output logic          done,
    output logic          irq
);

    ch_state_e     state_q, state_n;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q, credit_q;
    amode_e        smode_q, dmode_q;
    xmode_e        xmode_q;
    trig_e         trig_q;
    logic [1:0]    size_q;
    logic [BW-1:0] blk_q;
    logic          irqen_q, done_q;
    logic          ext_q, per_q;

    logic          trig_evt, trig_lvl, last, arm;
    logic [AW-1:0] step;
    logic [CW-1:0] credit_load;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] a,
                                              input amode_e m,
                                              input logic [AW-1:0] s);
        logic [AW-1:0] r;
        unique case (m)
            AM_INC:  r = a + s;
            AM_DEC:  r = a - s;
            default: r = a;
        endcase
        return r;
    endfunction

    always_comb begin
        unique case (trig_q)
            TS_EXT: begin
                trig_evt = ext_lvl & ~ext_q;
                trig_lvl = ext_lvl;
            end
            TS_PER: begin
                trig_evt = per_lvl & ~per_q;
                trig_lvl = per_lvl;
            end
            default: begin
                trig_evt = sw_stb;
                trig_lvl = sw_stb;
            end
        endcase
    end

    assign last = (cnt_q == CW'(1));

    always_comb begin
        unique case (size_q)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    always_comb begin
        unique case (xmode_q)
            XM_STEP:  credit_load = CW'(1);
            XM_BLOCK: credit_load = (blk_q == '0) ? CW'(1) : CW'(blk_q);
            default:  credit_load = cnt_q;
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (ld && ld_count != '0) state_n = CH_WAIT;
            end
            CH_WAIT: begin
                if (beat_done && last)                        state_n = CH_OFF;
                else if (xmode_q != XM_DEMAND && trig_evt)    state_n = CH_GO;
            end
            CH_GO: begin
                if (beat_done) begin
                    if (last)                      state_n = CH_OFF;
                    else if (credit_q == CW'(1))   state_n = CH_WAIT;
                end
            end
            default: state_n = CH_OFF;
        endcase
    end

    assign arm = (state_q == CH_WAIT) && (state_n == CH_GO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_n;
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            credit_q <= '0;
            smode_q  <= AM_INC;
            dmode_q  <= AM_INC;
            xmode_q  <= XM_DEMAND;
            trig_q   <= TS_EXT;
            size_q   <= '0;
            blk_q    <= '0;
            irqen_q  <= 1'b0;
            done_q   <= 1'b0;
            ext_q    <= 1'b0;
            per_q    <= 1'b0;
        end else begin
            ext_q <= ext_lvl;
            per_q <= per_lvl;
            if (state_q == CH_OFF && ld) begin
                src_q   <= ld_src;
                dst_q   <= ld_dst;
                cnt_q   <= ld_count;
                smode_q <= amode_e'(ld_smode);
                dmode_q <= amode_e'(ld_dmode);
                size_q  <= ld_size;
                xmode_q <= xmode_e'(ld_xmode);
                trig_q  <= trig_e'(ld_trig);
                blk_q   <= ld_blk;
                irqen_q <= ld_irqen;
            end else if (beat_done) begin
                src_q <= advance(src_q, smode_q, step);
                dst_q <= advance(dst_q, dmode_q, step);
                cnt_q <= cnt_q - CW'(1);
            end
            if (arm)                                credit_q <= credit_load;
            else if (state_q == CH_GO && beat_done) credit_q <= credit_q - CW'(1);
            if (beat_done && last)                  done_q <= 1'b1;
            else if (state_q == CH_OFF && ld)       done_q <= 1'b0;
            else if (done_clr)                      done_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        req    = (state_q == CH_GO) ||
                 (state_q == CH_WAIT && xmode_q == XM_DEMAND && trig_lvl);
        hold   = (state_q == CH_GO) && (xmode_q == XM_BURST) && !last;
        active = (state_q != CH_OFF);
        src    = src_q;
        dst    = dst_q;
        size   = size_q;
        done   = done_q;
        irq    = done_q & irqen_q;
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NCH = 5,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic [IW-1:0]  gnt_idx,
    output logic           gnt_any
);

    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IW'(i);
                gnt_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int NCH = 5,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  gnt_idx,
    input  logic           gnt_any,
    input  logic [NCH-1:0] hold,
    input  logic [AW-1:0]  src_a [NCH],
    input  logic [AW-1:0]  dst_a [NCH],
    input  logic [1:0]     size_a [NCH],
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic [NCH-1:0] beat_done,
    output logic           mv_start
);

    mv_state_e     st_q, st_n;
    logic [IW-1:0] cur_q;
    logic [DW-1:0] dbuf_q;

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            MV_IDLE:  if (gnt_any)   st_n = MV_READ;
            MV_READ:  if (mem_ready) st_n = MV_WRITE;
            MV_WRITE: if (mem_ready) st_n = hold[cur_q] ? MV_READ : MV_IDLE;
            default:  st_n = MV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MV_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            dbuf_q <= '0;
        end else begin
            if (st_q == MV_IDLE && gnt_any)  cur_q  <= gnt_idx;
            if (st_q == MV_READ && mem_ready) dbuf_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req   = (st_q != MV_IDLE);
        mem_we    = (st_q == MV_WRITE);
        mem_addr  = (st_q == MV_WRITE) ? dst_a[cur_q] : src_a[cur_q];
        mem_size  = size_a[cur_q];
        mem_wdata = dbuf_q;
        mv_start  = (st_q == MV_IDLE) && gnt_any;
        beat_done = '0;
        if (st_q == MV_WRITE && mem_ready) beat_done[cur_q] = 1'b1;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int NCH = 5,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int BW  = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_ch,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_count,
    input  logic [1:0]     cfg_smode,
    input  logic [1:0]     cfg_dmode,
    input  logic [1:0]     cfg_size,
    input  logic [1:0]     cfg_xmode,
    input  logic [1:0]     cfg_trig,
    input  logic [BW-1:0]  cfg_blk,
    input  logic           cfg_irqen,
    input  logic [NCH-1:0] ext_req,
    input  logic [NCH-1:0] per_req,
    input  logic [NCH-1:0] sw_trig,
    input  logic [NCH-1:0] done_clr,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic [NCH-1:0] ch_active,
    output logic [NCH-1:0] ch_done,
    output logic [NCH-1:0] ch_irq
);

    logic [NCH-1:0] ch_req, ch_hold, beat_done;
    logic [AW-1:0]  src_a  [NCH];
    logic [AW-1:0]  dst_a  [NCH];
    logic [1:0]     size_a [NCH];
    logic [IW-1:0]  gnt_idx;
    logic           gnt_any, mv_start;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chan #(.AW(AW), .CW(CW), .BW(BW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld        (cfg_we && (cfg_ch == IW'(i))),
            .ld_src    (cfg_src),
            .ld_dst    (cfg_dst),
            .ld_count  (cfg_count),
            .ld_smode  (cfg_smode),
            .ld_dmode  (cfg_dmode),
            .ld_size   (cfg_size),
            .ld_xmode  (cfg_xmode),
            .ld_trig   (cfg_trig),
            .ld_blk    (cfg_blk),
            .ld_irqen  (cfg_irqen),
            .ext_lvl   (ext_req[i]),
            .per_lvl   (per_req[i]),
            .sw_stb    (sw_trig[i]),
            .beat_done (beat_done[i]),
            .done_clr  (done_clr[i]),
            .req       (ch_req[i]),
            .hold      (ch_hold[i]),
            .src       (src_a[i]),
            .dst       (dst_a[i]),
            .size      (size_a[i]),
            .active    (ch_active[i]),
            .done      (ch_done[i]),
            .irq       (ch_irq[i])
        );
    end

    dma_prio_arb #(.NCH(NCH)) u_arb (
        .req     (ch_req),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    dma_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_idx   (gnt_idx),
        .gnt_any   (gnt_any),
        .hold      (ch_hold),
        .src_a     (src_a),
        .dst_a     (dst_a),
        .size_a    (size_a),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .beat_done (beat_done),
        .mv_start  (mv_start)
    );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH = 5,
    parameter int AW  = 32,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ready,
    input logic [AW-1:0]  mem_addr,
    input logic [1:0]     mem_size,
    input logic [NCH-1:0] ch_active,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] ch_irq,
    input logic [NCH-1:0] ch_req,
    input logic [NCH-1:0] beat_done,
    input logic [IW-1:0]  gnt_idx,
    input logic           mv_start
);

    logic higher_pending;

    always_comb begin
        higher_pending = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (i < int'(gnt_idx) && ch_req[i]) higher_pending = 1'b1;
        end
    end

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_size)));

    a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    a_r2_single_beat_end: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(beat_done));

    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (!higher_pending && ch_req[gnt_idx]));

    a_r10_done_means_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done & ch_active) == '0);

    a_r10_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq & ~ch_done) == '0);

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .ch_active (ch_active),
    .ch_done   (ch_done),
    .ch_irq    (ch_irq),
    .ch_req    (ch_req),
    .beat_done (beat_done),
    .gnt_idx   (gnt_idx),
    .mv_start  (mv_start)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_smode = '0, cfg_dmode = '0, cfg_size = '0;
    logic [1:0]  cfg_xmode = '0, cfg_trig = '0;
    logic [7:0]  cfg_blk = '0;
    logic        cfg_irqen = 1'b0;
    logic [4:0]  ext_req = '0, per_req = '0, sw_trig = '0, done_clr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;
    logic [4:0]  ch_active, ch_done, ch_irq;

    always #10 clk = ~clk;

    function automatic logic [31:0] rdf(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16]};
    endfunction

    assign mem_rdata = rdf(mem_addr);

    dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_smode(cfg_smode), .cfg_dmode(cfg_dmode), .cfg_size(cfg_size),
        .cfg_xmode(cfg_xmode), .cfg_trig(cfg_trig), .cfg_blk(cfg_blk),
        .cfg_irqen(cfg_irqen), .ext_req(ext_req), .per_req(per_req),
        .sw_trig(sw_trig), .done_clr(done_clr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ch_active(ch_active), .ch_done(ch_done), .ch_irq(ch_irq)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } txn_t;

    txn_t        expq[$];
    int          nchk = 0, nerr = 0;
    int          cyc = 0, rd_cnt = 0, wr_cnt = 0;
    bit          wr_now = 0;
    string       tag = "R1";
    logic [31:0] m_src[5], m_dst[5];
    logic [1:0]  m_sm[5], m_dm[5], m_sz[5];

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] stp(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] m,
                                        input logic [1:0] sz);
        return (m == 2'd0) ? a + stp(sz) : (m == 2'd1) ? a - stp(sz) : a;
    endfunction

    // reference transaction stream, compared on every clock
    always @(negedge clk) begin
        bit rdy;
        txn_t e;
        cyc++;
        wr_now = 0;
        rdy = ((cyc % 5) != 2) && ((cyc % 7) != 4);
        mem_ready = rdy;
        if (rst_n && mem_req && rdy) begin
            if (expq.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL %s: unexpected beat actual=%0h expected=none", tag, mem_addr);
            end else begin
                e = expq.pop_front();
                check({tag, " R2 phase"}, {31'd0, mem_we}, {31'd0, e.we});
                check({tag, " R3 addr"}, mem_addr, e.addr);
                check({tag, " R3 size"}, {30'd0, mem_size}, {30'd0, e.size});
                if (e.we) check({tag, " R2 data"}, mem_wdata, e.data);
            end
            if (mem_we) begin wr_cnt++; wr_now = 1; end
            else rd_cnt++;
        end
    end

    task automatic step_n(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic cfg(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] n, input logic [1:0] sm, input logic [1:0] dm,
                       input logic [1:0] sz, input logic [1:0] xm, input logic [1:0] tr,
                       input logic [7:0] blk, input logic ie, input bit upd);
        cfg_ch = 3'(ch); cfg_src = s; cfg_dst = d; cfg_count = n;
        cfg_smode = sm; cfg_dmode = dm; cfg_size = sz; cfg_xmode = xm;
        cfg_trig = tr; cfg_blk = blk; cfg_irqen = ie; cfg_we = 1'b1;
        step_n(1);
        cfg_we = 1'b0;
        if (upd) begin
            m_src[ch] = s; m_dst[ch] = d; m_sm[ch] = sm; m_dm[ch] = dm; m_sz[ch] = sz;
        end
    endtask

    task automatic push_beats(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            expq.push_back({1'b0, m_src[ch], m_sz[ch], 32'd0});
            expq.push_back({1'b1, m_dst[ch], m_sz[ch], rdf(m_src[ch])});
            m_src[ch] = adv(m_src[ch], m_sm[ch], m_sz[ch]);
            m_dst[ch] = adv(m_dst[ch], m_dm[ch], m_sz[ch]);
        end
    endtask

    task automatic pulse_sw(input logic [4:0] m);
        sw_trig = m; step_n(1); sw_trig = '0;
    endtask

    task automatic wait_done(input int ch, input string t);
        int k = 0;
        while (!ch_done[ch] && k < 3000) begin step_n(1); k++; end
        check({t, " done"}, {31'd0, ch_done[ch]}, 32'd1);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        int target;
        // R1 reset state
        step_n(3);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 active", {27'd0, ch_active}, 32'd0);
        check("R1 done", {27'd0, ch_done}, 32'd0);
        rst_n = 1'b1;
        step_n(2);
        check("R1 irq after", {27'd0, ch_irq}, 32'd0);
        check("R1 req after", {31'd0, mem_req}, 32'd0);

        // R7 burst, R3 inc source / dec destination, 16-bit, R10 irq on
        tag = "R7";
        cfg(2, 32'h1000, 32'h2000, 16'd4, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 8'd0, 1'b1, 1);
        check("R10 active after load", {31'd0, ch_active[2]}, 32'd1);
        push_beats(2, 4);
        pulse_sw(5'b00100);
        wait_done(2, "R7");
        check("R7 all beats from one trigger", expq.size(), 0);
        check("R10 active cleared", {31'd0, ch_active[2]}, 32'd0);
        check("R10 irq enabled", {31'd0, ch_irq[2]}, 32'd1);

        // R3 32-bit inc src fixed dst; then 8-bit dec src inc dst, R10 irq off
        tag = "R3";
        cfg(2, 32'h3000, 32'h3800, 16'd3, 2'd0, 2'd2, 2'd2, 2'd1, 2'd2, 8'd0, 1'b0, 1);
        check("R11 load clears done", {31'd0, ch_done[2]}, 32'd0);
        push_beats(2, 3);
        pulse_sw(5'b00100);
        wait_done(2, "R3 word");
        cfg(2, 32'h4003, 32'h4100, 16'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd3, 8'd0, 1'b0, 1);
        push_beats(2, 2);
        pulse_sw(5'b00100);
        wait_done(2, "R3 byte");
        check("R10 irq disabled", {31'd0, ch_irq[2]}, 32'd0);
        check("R3 stream drained", expq.size(), 0);

        // R4 / R5 step with external trigger
        tag = "R5";
        cfg(1, 32'h5000, 32'h5400, 16'd3, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 8'd0, 1'b0, 1);
        per_req[1] = 1'b1; sw_trig[1] = 1'b1; step_n(1); sw_trig = '0; step_n(2);
        per_req[1] = 1'b0; ext_req[0] = 1'b1; step_n(1); ext_req[0] = 1'b0;
        step_n(20);
        check("R4 unselected lines ignored", {31'd0, ch_active[1]}, 32'd1);
        push_beats(1, 1);
        ext_req[1] = 1'b1;
        step_n(40);
        check("R5 one beat for held level", expq.size(), 0);
        check("R5 still active", {31'd0, ch_active[1]}, 32'd1);
        ext_req[1] = 1'b0; step_n(2);
        push_beats(1, 1); ext_req[1] = 1'b1; step_n(30); ext_req[1] = 1'b0; step_n(2);
        push_beats(1, 1); ext_req[1] = 1'b1;
        wait_done(1, "R5");
        ext_req[1] = 1'b0;

        // R6 block with peripheral trigger, truncated at count
        tag = "R6";
        cfg(3, 32'h6000, 32'h6800, 16'd3, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1, 8'd2, 1'b1, 1);
        push_beats(3, 2);
        per_req[3] = 1'b1; ext_req[3] = 1'b1; step_n(2);
        per_req[3] = 1'b0; ext_req[3] = 1'b0;
        step_n(40);
        check("R6 block of two", expq.size(), 0);
        check("R6 still active", {31'd0, ch_active[3]}, 32'd1);
        push_beats(3, 1);
        per_req[3] = 1'b1; step_n(2); per_req[3] = 1'b0;
        wait_done(3, "R6 truncated block");

        // R8 demand on external level
        tag = "R8";
        cfg(4, 32'h7000, 32'h7800, 16'd4, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 8'd0, 1'b0, 1);
        push_beats(4, 2);
        target = wr_cnt + 2;
        ext_req[4] = 1'b1;
        while (wr_cnt < target) step_n(1);
        step_n(1);
        ext_req[4] = 1'b0;
        step_n(30);
        check("R8 stops when low", expq.size(), 0);
        check("R8 still active", {31'd0, ch_active[4]}, 32'd1);
        push_beats(4, 2);
        ext_req[4] = 1'b1;
        wait_done(4, "R8 resume");
        ext_req[4] = 1'b0;

        // R9 simultaneous triggers, lowest channel first
        tag = "R9";
        cfg(3, 32'h8000, 32'h8100, 16'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 8'd0, 1'b0, 1);
        cfg(0, 32'h8200, 32'h8300, 16'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 8'd0, 1'b0, 1);
        push_beats(0, 1);
        push_beats(3, 1);
        pulse_sw(5'b01001);
        wait_done(3, "R9 ch3");
        check("R9 ch0 done", {31'd0, ch_done[0]}, 32'd1);

        // R7 burst holds the port against channel 0
        tag = "R7 hold";
        cfg(4, 32'h9010, 32'h9100, 16'd3, 2'd1, 2'd0, 2'd2, 2'd1, 2'd2, 8'd0, 1'b0, 1);
        cfg(0, 32'h9200, 32'h9300, 16'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 8'd0, 1'b0, 1);
        push_beats(4, 3);
        push_beats(0, 1);
        target = rd_cnt + 1;
        pulse_sw(5'b10000);
        while (rd_cnt < target) step_n(1);
        pulse_sw(5'b00001);
        wait_done(0, "R7 hold ch0");
        check("R7 ch4 done", {31'd0, ch_done[4]}, 32'd1);

        // R12 load while active is ignored
        tag = "R12";
        cfg(1, 32'hA000, 32'hA400, 16'd2, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 8'd0, 1'b0, 1);
        cfg(1, 32'hF000, 32'hF400, 16'd7, 2'd1, 2'd1, 2'd0, 2'd1, 2'd2, 8'd0, 1'b1, 0);
        push_beats(1, 2);
        pulse_sw(5'b00010); step_n(30);
        pulse_sw(5'b00010);
        wait_done(1, "R12");
        check("R12 irq enable unchanged", {31'd0, ch_irq[1]}, 32'd0);

        // R11 done set and clear in the same cycle
        tag = "R11";
        cfg(1, 32'hB000, 32'hB400, 16'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 8'd0, 1'b1, 1);
        push_beats(1, 1);
        pulse_sw(5'b00010);
        while (!wr_now) step_n(1);
        done_clr[1] = 1'b1;
        step_n(1);
        done_clr[1] = 1'b0;
        step_n(1);
        check("R11 set wins", {31'd0, ch_done[1]}, 32'd1);
        check("R11 irq kept", {31'd0, ch_irq[1]}, 32'd1);
        done_clr[1] = 1'b1; step_n(1); done_clr[1] = 1'b0; step_n(1);
        check("R11 clear alone", {31'd0, ch_done[1]}, 32'd0);
        check("R11 irq cleared", {31'd0, ch_irq[1]}, 32'd0);
        check("R11 stream drained", expq.size(), 0);

        step_n(5);
        report();
    end

endmodule